// File: doc/BRIEF.md
# Multiplexed Serial Digit Readout Port

This block turns a keypad tone position into a 4-bit digit code and lets an external controller read that code one bit at a time over a single shared output pin. The controller supplies the read clock as acknowledge pulses. Each rising edge of a pulse puts the next bit on the pin, least significant bit first. The read clock is asynchronous, so it is resynchronised to the system clock and its edges are detected there.

A digit can be read only while the steering input says a valid tone is present. Once a readout has started, it has to run to the end of its fourth pulse before another digit can be captured. When no readout is in progress, the same pin carries the energy-present level. A controller that watches the pin between reads therefore sees the signal envelope.

Top module: `serial_digit_port`

## Requirements
- R1: `key_code` is a combinational function of `tone_row` and `tone_col`. The keypad rows, from row 0 to row 3, are "1 2 3 A", "4 5 6 B", "7 8 9 C" and "* 0 # D", with the columns running 0 to 3. Digits 1 to 9 map to their own value and 0 maps to 10. `*` maps to 11 and `#` maps to 12. A, B and C map to 13, 14 and 15, and D maps to 0.
- R2: A readout starts on a detected rising edge of `ack_in`, but only if `steer_valid` is high and the current steering period has not yet been read. At that edge, `key_code` is captured and its bit 0 appears on `sd_pin`. This happens at the third system clock edge after `ack_in` goes high.
- R3: The second, third and fourth rising edges of `ack_in` in a readout put captured bits 1, 2 and 3 on `sd_pin`, in that order.
- R4: A readout window opens on the first rising edge and closes on the falling edge of the fourth pulse. Outside a window, `sd_pin` equals `energy_det`. Inside a window, it holds the current data bit whatever `energy_det` does.
- R5: While fewer than four pulses have been applied, the window stays open. No new code is captured, even if `steer_valid` drops, the tone position changes and `steer_valid` rises again.
- R6: Once a digit has been read, further pulses do not start a readout while `steer_valid` stays high. A new readout needs `steer_valid` to go low first.
- R7: A rising edge of `ack_in` while `steer_valid` is low and no window is open starts nothing, and `sd_pin` keeps following `energy_det`.
- R8: After reset, no window is open, a fresh steering period is readable, and `sd_pin` follows `energy_det`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tone_row | input | 2 | Detected row tone index |
| tone_col | input | 2 | Detected column tone index |
| steer_valid | input | 1 | High while a valid digit tone is present |
| energy_det | input | 1 | Energy-present level, shown on the pin between reads |
| ack_in | input | 1 | External read clock, asynchronous |
| key_code | output | 4 | Combinational digit code from the lookup |
| sd_pin | output | 1 | Shared serial data / energy pin |

## Verification
All sixteen row and column positions are applied. Each one is checked on the lookup output and then read out in full. During every bit, `energy_det` is driven to the opposite of the expected bit, so a pin that leaked the energy level or took the wrong bit shows a mismatch. After the fourth fall, both energy levels are applied, which separates a window that closes too early or too late. Extra pulses under an unchanged steering period, pulses with steering low, and a readout interrupted after two pulses by a new digit each show whether capture is correctly refused.

// File: rtl/serial_digit_pkg.sv
package serial_digit_pkg;
   localparam int unsigned DIGIT_BITS = 4;
   localparam int unsigned INDEX_BITS = 2;
   localparam int unsigned MIN_SYNC   = 2;
   typedef logic [DIGIT_BITS-1:0] digit_code_t;
endpackage

// File: rtl/sdp_ack_sync.sv
module sdp_ack_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ack_async,
   output logic rise_o,
   output logic fall_o
);
   localparam int unsigned LAST = STAGES - 1;

   if (STAGES < serial_digit_pkg::MIN_SYNC) begin : g_bad_stages
      $error("sdp_ack_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[0] <= 1'b0;
      else        chain_q[0] <= ack_async;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q[s] <= 1'b0;
         else        chain_q[s] <= chain_q[s-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= chain_q[LAST];
   end

   assign rise_o = chain_q[LAST] & ~prev_q;
   assign fall_o = ~chain_q[LAST] & prev_q;
endmodule

// File: rtl/sdp_keypad_lut.sv
module sdp_keypad_lut #(
   parameter int unsigned IDX_W  = 2,
   parameter int unsigned CODE_W = 4
) (
   input  logic [IDX_W-1:0]  row_i,
   input  logic [IDX_W-1:0]  col_i,
   output logic [CODE_W-1:0] code_o
);
   if (IDX_W != serial_digit_pkg::INDEX_BITS) begin : g_bad_idx
      $error("sdp_keypad_lut: IDX_W must be 2");
   end
   if (CODE_W != serial_digit_pkg::DIGIT_BITS) begin : g_bad_code
      $error("sdp_keypad_lut: CODE_W must be 4");
   end

   localparam logic [IDX_W-1:0] EDGE_IDX = '1;
   localparam logic [CODE_W-1:0] CODE_STAR = CODE_W'(11);
   localparam logic [CODE_W-1:0] CODE_ZERO = CODE_W'(10);
   localparam logic [CODE_W-1:0] CODE_HASH = CODE_W'(12);
   localparam logic [CODE_W-1:0] CODE_LTR  = CODE_W'(13);

   logic [CODE_W-1:0] row_w, col_w;

   always_comb begin
      row_w = CODE_W'(row_i);
      col_w = CODE_W'(col_i);
      if (col_i == EDGE_IDX) begin
         if (row_i == EDGE_IDX) code_o = '0;
         else                   code_o = CODE_LTR + row_w;
      end else if (row_i == EDGE_IDX) begin
         case (col_i)
            2'd0:    code_o = CODE_STAR;
            2'd1:    code_o = CODE_ZERO;
            default: code_o = CODE_HASH;
         endcase
      end else begin
         code_o = (row_w << 1) + row_w + col_w + CODE_W'(1);
      end
   end
endmodule

// File: rtl/sdp_shift_seq.sv
module sdp_shift_seq #(
   parameter int unsigned CODE_W = 4,
   localparam int unsigned CNT_W = $clog2(CODE_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rise_i,
   input  logic              fall_i,
   input  logic              steer_i,
   input  logic [CODE_W-1:0] code_i,
   output logic              win_o,
   output logic              bit_o,
   output logic [CNT_W-1:0]  cnt_o,
   output logic              armed_o
);
   localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(CODE_W);

   logic              win_q, bit_q, armed_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [CODE_W-1:0] shreg_q;
   logic              start_w, step_w, close_w;

   assign start_w = !win_q && rise_i && steer_i && armed_q;
   assign step_w  = win_q && rise_i && (cnt_q < LAST_CNT);
   assign close_w = win_q && fall_i && (cnt_q == LAST_CNT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_q   <= 1'b0;
         bit_q   <= 1'b0;
         armed_q <= 1'b1;
         cnt_q   <= '0;
         shreg_q <= '0;
      end else begin
         if (!steer_i) armed_q <= 1'b1;
         if (start_w) begin
            win_q   <= 1'b1;
            cnt_q   <= CNT_W'(1);
            bit_q   <= code_i[0];
            shreg_q <= code_i >> 1;
            armed_q <= 1'b0;
         end else if (step_w) begin
            bit_q   <= shreg_q[0];
            shreg_q <= shreg_q >> 1;
            cnt_q   <= cnt_q + 1'b1;
         end else if (close_w) begin
            win_q <= 1'b0;
            cnt_q <= '0;
         end
      end
   end

   assign win_o   = win_q;
   assign bit_o   = bit_q;
   assign cnt_o   = cnt_q;
   assign armed_o = armed_q;
endmodule

// File: rtl/serial_digit_port.sv
module serial_digit_port #(
   parameter int unsigned CODE_W      = serial_digit_pkg::DIGIT_BITS,
   parameter int unsigned IDX_W       = serial_digit_pkg::INDEX_BITS,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  tone_row,
   input  logic [IDX_W-1:0]  tone_col,
   input  logic              steer_valid,
   input  logic              energy_det,
   input  logic              ack_in,
   output logic [CODE_W-1:0] key_code,
   output logic              sd_pin
);
   localparam int unsigned CNT_W = $clog2(CODE_W + 1);

   logic             ack_rise, ack_fall;
   logic             rd_win, rd_bit, rd_armed;
   logic [CNT_W-1:0] rd_cnt;

   sdp_keypad_lut #(.IDX_W(IDX_W), .CODE_W(CODE_W)) u_lut (
      .row_i  (tone_row),
      .col_i  (tone_col),
      .code_o (key_code)
   );

   sdp_ack_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .ack_async (ack_in),
      .rise_o    (ack_rise),
      .fall_o    (ack_fall)
   );

   sdp_shift_seq #(.CODE_W(CODE_W)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .rise_i  (ack_rise),
      .fall_i  (ack_fall),
      .steer_i (steer_valid),
      .code_i  (key_code),
      .win_o   (rd_win),
      .bit_o   (rd_bit),
      .cnt_o   (rd_cnt),
      .armed_o (rd_armed)
   );

   assign sd_pin = rd_win ? rd_bit : energy_det;
endmodule

// File: rtl/serial_digit_port_chk.sv
module serial_digit_port_chk #(
   parameter int unsigned CODE_W = 4,
   localparam int unsigned CNT_W = $clog2(CODE_W + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              steer_valid,
   input logic [CODE_W-1:0] key_code,
   input logic              sd_pin,
   input logic              ack_rise,
   input logic              ack_fall,
   input logic              rd_win,
   input logic              rd_armed,
   input logic [CNT_W-1:0]  rd_cnt
);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(CODE_W);

   logic [CODE_W-1:0] cap_q;
   logic              start_seen;
   assign start_seen = ack_rise && steer_valid && rd_armed && !rd_win;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cap_q <= '0;
      else if (start_seen) cap_q <= key_code;
   end

   // R2
   start_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_seen |=> rd_win && (sd_pin == $past(key_code[0])));

   // R3
   next_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_win && ack_rise && rd_cnt != '0 && rd_cnt < FULL) |=> (sd_pin == cap_q[$past(rd_cnt)]));

   // R4
   close_on_fourth_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rd_win) |-> ($past(ack_fall) && $past(rd_cnt) == FULL));

   // R5
   hold_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_win && !(ack_fall && rd_cnt == FULL)) |=> rd_win);

   // R6
   no_reread_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_rise && !rd_armed && !rd_win) |=> !rd_win);

   // R7
   no_steer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_rise && !steer_valid && !rd_win) |=> !rd_win);
endmodule

bind serial_digit_port serial_digit_port_chk #(.CODE_W(CODE_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .steer_valid (steer_valid),
   .key_code    (key_code),
   .sd_pin      (sd_pin),
   .ack_rise    (ack_rise),
   .ack_fall    (ack_fall),
   .rd_win      (rd_win),
   .rd_armed    (rd_armed),
   .rd_cnt      (rd_cnt)
);

// File: tb/serial_digit_port_tb_top.sv
module serial_digit_port_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] tone_row = '0, tone_col = '0;
   logic       steer_valid = 1'b0, energy_det = 1'b0, ack_in = 1'b0;
   logic [3:0] key_code;
   logic       sd_pin;

   int vectors = 0;
   int fails = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   serial_digit_port dut_i (
      .clk(clk), .rst_n(rst_n), .tone_row(tone_row), .tone_col(tone_col),
      .steer_valid(steer_valid), .energy_det(energy_det), .ack_in(ack_in),
      .key_code(key_code), .sd_pin(sd_pin)
   );

   localparam string KEYS = "123A456B789C*0#D";

   function automatic logic [3:0] expect_code(int r, int c);
      byte ch = KEYS[r*4 + c];
      if (ch >= "1" && ch <= "9") return 4'(ch - "0");
      if (ch == "0") return 4'd10;
      if (ch == "*") return 4'd11;
      if (ch == "#") return 4'd12;
      return 4'((ch - "A" + 13) % 16);
   endfunction

   task automatic check(string req, logic [3:0] act, logic [3:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic wait_n(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic ack_up();  ack_in = 1'b1; wait_n(5); endtask
   task automatic ack_dn();  ack_in = 1'b0; wait_n(5); endtask

   task automatic read_bits(logic [3:0] code, int first, int last, string req);
      for (int i = first; i <= last; i++) begin
         energy_det = ~code[i];
         ack_up();
         check(req, {3'b0, sd_pin}, {3'b0, code[i]});
         energy_det = code[i];
         ack_dn();
         if (i < 3) begin
            energy_det = ~code[i];
            wait_n(1);
            check("R4", {3'b0, sd_pin}, {3'b0, code[i]});
         end
      end
   endtask

   task automatic check_energy(string req);
      for (int e = 0; e < 2; e++) begin
         energy_det = e[0];
         wait_n(1);
         check(req, {3'b0, sd_pin}, {3'b0, e[0]});
      end
   endtask

   initial begin
      wait_n(3);
      check_energy("R8");
      rst_n = 1'b1;
      wait_n(2);
      check_energy("R8");

      for (int r = 0; r < 4; r++) begin
         for (int c = 0; c < 4; c++) begin
            logic [3:0] exp;
            exp = expect_code(r, c);
            tone_row = 2'(r); tone_col = 2'(c);
            wait_n(1);
            check("R1", key_code, exp);
            steer_valid = 1'b1;
            wait_n(1);
            read_bits(exp, 0, 0, "R2");
            read_bits(exp, 1, 3, "R3");
            check_energy("R4");
            // R6: extra pulse, steering unchanged
            energy_det = ~exp[0];
            ack_up();
            check("R6", {3'b0, sd_pin}, {3'b0, ~exp[0]});
            ack_dn();
            check_energy("R6");
            steer_valid = 1'b0;
            wait_n(2);
            // R7: pulse with steering low
            energy_det = ~exp[0];
            ack_up();
            check("R7", {3'b0, sd_pin}, {3'b0, ~exp[0]});
            ack_dn();
            check_energy("R7");
         end
      end

      // R5: interrupted readout, new digit must not be captured
      begin
         logic [3:0] a, b;
         a = expect_code(0, 1);
         b = expect_code(3, 2);
         tone_row = 2'd0; tone_col = 2'd1; steer_valid = 1'b1;
         wait_n(2);
         read_bits(a, 0, 1, "R5");
         steer_valid = 1'b0;
         wait_n(3);
         tone_row = 2'd3; tone_col = 2'd2; steer_valid = 1'b1;
         wait_n(3);
         read_bits(a, 2, 3, "R5");
         check_energy("R5");
         steer_valid = 1'b0;
         wait_n(3);
         steer_valid = 1'b1;
         wait_n(2);
         read_bits(b, 0, 3, "R5");
         check_energy("R5");
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end
endmodule